// File: doc/BRIEF.md
# Pixel-Clock Frame Capture Writer

This block takes the output of an 8-bit parallel image sensor and turns one frame of it into a stream of 16-bit writes for the write port of an on-chip dual-port RAM. Every register runs on the rising edge of the sensor's pixel clock. The vertical sync and line-valid inputs are sampled as ordinary data and are never used as clocks. A frame begins at a falling edge of the sampled vertical sync. This edge clears the counters, the error flags and the word address.

While a frame is active, each byte seen with line-valid high is accepted. Two consecutive accepted bytes are packed into one word, and the words go out with a linear address. A falling edge of line-valid closes the line. A line with an odd byte count writes its last byte with a zero upper half and raises an error flag. Bytes beyond the configured line length are dropped and raise an overflow flag. When the configured number of lines has closed, a one-cycle done pulse is issued, and the block then ignores the sensor until the next frame start. Its defaults match a 664 x 492 frame.

Top module: `cam_frame_writer`

## Requirements
- R1: A frame start is a rising clock edge at which `vsync_i` is 0 and its sample from the previous edge was 1 (this sample resets to 0). A frame start clears `line_cnt_o`, `line_err_o`, `ovf_err_o`, any pending byte and the word address.
- R2: Before the first frame start after reset, no write is issued, whatever `hvalid_i` and `pix_i` do.
- R3: A byte is accepted only at a rising edge where `hvalid_i` is 1 during an active frame. `pix_i` has no effect while `hvalid_i` is 0.
- R4: The first byte of each pair is written to `wr_data_o[7:0]` and the second to `wr_data_o[15:8]`. `wr_en_o` is high for exactly one cycle, the cycle after the edge that accepted the second byte.
- R5: The first write of a frame uses address 0, and each later write uses the previous address plus one, across line boundaries.
- R6: A falling edge of `hvalid_i` during an active frame ends a line and increments `line_cnt_o` by one.
- R7: If a line ends with an odd number of accepted bytes, the pending byte is written with `wr_data_o[15:8]` = 0, and `line_err_o` is set and held until the next frame start.
- R8: Bytes after the first LINE_PIX of a line are dropped, and `ovf_err_o` is set and held until the next frame start.
- R9: When `line_cnt_o` reaches FRAME_LINES, `done_o` pulses high for one cycle. After that, line activity causes no writes and no count change until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync_i | input | 1 | Vertical sync, sampled as data |
| hvalid_i | input | 1 | Line-valid: high while pixel bytes are on the bus |
| pix_i | input | PIX_W | Pixel byte |
| wr_en_o | output | 1 | RAM write strobe |
| wr_addr_o | output | ADDR_W | RAM word address |
| wr_data_o | output | 2*PIX_W | Packed word: earlier byte low, later byte high |
| line_cnt_o | output | LCNT_W | Lines closed in the current frame |
| done_o | output | 1 | One-cycle pulse when the frame is complete |
| line_err_o | output | 1 | Sticky: a line had an odd byte count |
| ovf_err_o | output | 1 | Sticky: a line exceeded LINE_PIX bytes |

## Verification
The bench builds the block with LINE_PIX = 6 and FRAME_LINES = 3. This gives a frame of at most nine words, so every write can be compared one by one against arithmetic expectations. It sweeps the line length from 1 to 8. That range covers odd and even lines below the limit, a line exactly at the limit, and two lengths past it, so the zero-filled flush, the overflow drop and the address run across lines are each reached in several frames. Line activity before the first frame start and after the done pulse is also driven, to confirm that it is ignored.

// File: rtl/cfw_pkg.sv
package cfw_pkg;
  // Words needed for one line of pix bytes (an odd byte takes a word of its own).
  function automatic int words_per_line(input int pix);
    return (pix + 1) / 2;
  endfunction

  // Words needed for a full frame.
  function automatic int frame_words(input int pix, input int lines);
    return lines * words_per_line(pix);
  endfunction

  // Width able to hold values 0..n-1 (at least 1).
  function automatic int width_for(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/cfw_edge.sv
module cfw_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic fall_o
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_i;
  end

  assign fall_o = sig_q & ~sig_i;
endmodule

// File: rtl/cfw_track.sv
module cfw_track #(
  parameter int LINE_PIX    = 664,
  parameter int FRAME_LINES = 492,
  parameter int PCNT_W      = 10,
  parameter int LCNT_W      = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_fall,
  input  logic              hvalid,
  output logic              active_o,
  output logic              accept_o,
  output logic              close_o,
  output logic              done_o,
  output logic              ovf_o,
  output logic [LCNT_W-1:0] line_cnt_o
);
  logic [PCNT_W-1:0] pix_cnt;
  logic              room;
  logic              excess;
  logic              last_line;

  assign room      = (pix_cnt < PCNT_W'(LINE_PIX));
  assign accept_o  = active_o & hvalid & ~frame_start & room;
  assign excess    = active_o & hvalid & ~frame_start & ~room;
  assign close_o   = active_o & line_fall & ~frame_start;
  assign last_line = (line_cnt_o == LCNT_W'(FRAME_LINES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_o   <= 1'b0;
      pix_cnt    <= '0;
      line_cnt_o <= '0;
      done_o     <= 1'b0;
      ovf_o      <= 1'b0;
    end else if (frame_start) begin
      active_o   <= 1'b1;
      pix_cnt    <= '0;
      line_cnt_o <= '0;
      done_o     <= 1'b0;
      ovf_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (accept_o) pix_cnt <= pix_cnt + 1'b1;
      if (excess)   ovf_o   <= 1'b1;
      if (close_o) begin
        pix_cnt    <= '0;
        line_cnt_o <= line_cnt_o + 1'b1;
        if (last_line) begin
          active_o <= 1'b0;
          done_o   <= 1'b1;
        end
      end
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !frame_start) |=> ovf_o);
  p_pix_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pix_cnt <= PCNT_W'(LINE_PIX));
  p_line_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_cnt_o <= LCNT_W'(FRAME_LINES));
endmodule

// File: rtl/cfw_pack.sv
module cfw_pack #(
  parameter int PIX_W  = 8,
  parameter int ADDR_W = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               accept,
  input  logic               close,
  input  logic [PIX_W-1:0]   pix,
  output logic               wr_en_o,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [2*PIX_W-1:0] wr_data_o,
  output logic               line_err_o
);
  logic [PIX_W-1:0]  lo_byte;
  logic              have_lo;
  logic [ADDR_W-1:0] next_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_byte    <= '0;
      have_lo    <= 1'b0;
      next_addr  <= '0;
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      line_err_o <= 1'b0;
    end else if (frame_start) begin
      have_lo    <= 1'b0;
      next_addr  <= '0;
      wr_en_o    <= 1'b0;
      line_err_o <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (accept) begin
        if (!have_lo) begin
          lo_byte <= pix;
          have_lo <= 1'b1;
        end else begin
          wr_en_o   <= 1'b1;
          wr_data_o <= {pix, lo_byte};
          wr_addr_o <= next_addr;
          next_addr <= next_addr + 1'b1;
          have_lo   <= 1'b0;
        end
      end else if (close && have_lo) begin
        wr_en_o    <= 1'b1;
        wr_data_o  <= {{PIX_W{1'b0}}, lo_byte};
        wr_addr_o  <= next_addr;
        next_addr  <= next_addr + 1'b1;
        have_lo    <= 1'b0;
        line_err_o <= 1'b1;
      end
    end
  end

  p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o);
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (next_addr != $past(next_addr)) |-> ((next_addr == $past(next_addr) + 1'b1) || (next_addr == '0)));
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (line_err_o && !frame_start) |=> line_err_o);
endmodule

// File: rtl/cam_frame_writer.sv
module cam_frame_writer #(
  parameter int PIX_W       = 8,
  parameter int LINE_PIX    = 664,
  parameter int FRAME_LINES = 492,
  localparam int ADDR_W = cfw_pkg::width_for(cfw_pkg::frame_words(LINE_PIX, FRAME_LINES)),
  localparam int PCNT_W = cfw_pkg::width_for(LINE_PIX + 1),
  localparam int LCNT_W = cfw_pkg::width_for(FRAME_LINES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vsync_i,
  input  logic               hvalid_i,
  input  logic [PIX_W-1:0]   pix_i,
  output logic               wr_en_o,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [2*PIX_W-1:0] wr_data_o,
  output logic [LCNT_W-1:0]  line_cnt_o,
  output logic               done_o,
  output logic               line_err_o,
  output logic               ovf_err_o
);
  // Named internal events
  logic frame_start;
  logic line_fall;
  logic active;
  logic accept;
  logic close;

  cfw_edge i_vs_edge (.clk(clk), .rst_n(rst_n), .sig_i(vsync_i),  .fall_o(frame_start));
  cfw_edge i_hv_edge (.clk(clk), .rst_n(rst_n), .sig_i(hvalid_i), .fall_o(line_fall));

  cfw_track #(
    .LINE_PIX(LINE_PIX), .FRAME_LINES(FRAME_LINES),
    .PCNT_W(PCNT_W), .LCNT_W(LCNT_W)
  ) i_track (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_fall(line_fall),
    .hvalid(hvalid_i), .active_o(active), .accept_o(accept), .close_o(close),
    .done_o(done_o), .ovf_o(ovf_err_o), .line_cnt_o(line_cnt_o)
  );

  cfw_pack #(.PIX_W(PIX_W), .ADDR_W(ADDR_W)) i_pack (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .accept(accept),
    .close(close), .pix(pix_i), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .line_err_o(line_err_o)
  );

  p_no_write_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !wr_en_o);
  p_frame_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (line_cnt_o == '0 && !line_err_o && !ovf_err_o && !wr_en_o));
  p_done_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (line_cnt_o == LCNT_W'(FRAME_LINES)));
endmodule

// File: tb/test_cam_frame_writer.sv
module test_cam_frame_writer;
  localparam int LP = 6;
  localparam int FL = 3;
  localparam int AW = 4;
  localparam int LW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          vsync_i, hvalid_i;
  logic [7:0]    pix_i;
  logic          wr_en_o, done_o, line_err_o, ovf_err_o;
  logic [AW-1:0] wr_addr_o;
  logic [15:0]   wr_data_o;
  logic [LW-1:0] line_cnt_o;

  int checks = 0, failures = 0;
  int wr_cnt = 0, done_cnt = 0;
  int got_addr [16];
  int got_data [16];

  always #2 clk = ~clk;

  cam_frame_writer #(.PIX_W(8), .LINE_PIX(LP), .FRAME_LINES(FL)) i_cam_frame_writer (
    .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i), .hvalid_i(hvalid_i), .pix_i(pix_i),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .line_cnt_o(line_cnt_o), .done_o(done_o), .line_err_o(line_err_o), .ovf_err_o(ovf_err_o)
  );

  always @(negedge clk) begin
    if (wr_en_o) begin
      if (wr_cnt < 16) begin
        got_addr[wr_cnt] = int'(wr_addr_o);
        got_data[wr_cnt] = int'(wr_data_o);
      end
      wr_cnt++;
    end
    if (done_o) done_cnt++;
  end

  function automatic int pv(input int f, input int l, input int i);
    return (f * 37 + l * 11 + i * 3 + 1) & 255;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_line(input int f, input int l, input int n);
    for (int i = 0; i < n; i++) begin
      hvalid_i = 1'b1;
      pix_i    = 8'(pv(f, l, i));
      @(negedge clk);
    end
    hvalid_i = 1'b0;
    for (int g = 0; g < 3; g++) begin
      pix_i = 8'(8'hA5 ^ g);  // bus moves while line-valid is low (R3)
      @(negedge clk);
    end
  endtask

  task automatic run_frame(input int L);
    int lc, wpl, lo, hi, ln, j, saved;
    wr_cnt = 0; done_cnt = 0;
    vsync_i = 1'b1; @(negedge clk); @(negedge clk);
    vsync_i = 1'b0; @(negedge clk);
    chk(line_cnt_o == 0 && !line_err_o && !ovf_err_o, "R1 frame start clears state",
        int'(line_cnt_o) + 10 * int'(line_err_o) + 100 * int'(ovf_err_o), 0);
    for (int l = 0; l < FL; l++) begin
      send_line(L, l, L);
      chk(int'(line_cnt_o) == l + 1, "R6 line count", int'(line_cnt_o), l + 1);
    end
    repeat (3) @(negedge clk);
    lc  = (L > LP) ? LP : L;
    wpl = (lc + 1) / 2;
    chk(wr_cnt == FL * wpl, "R4 write count", wr_cnt, FL * wpl);
    for (int k = 0; k < FL * wpl && k < 16; k++) begin
      ln = k / wpl; j = k % wpl;
      lo = pv(L, ln, 2 * j);
      hi = (2 * j + 1 < lc) ? pv(L, ln, 2 * j + 1) : 0;
      chk(got_addr[k] == k, "R5 address", got_addr[k], k);
      chk(got_data[k] == (hi * 256 + lo), "R4 R7 R3 packed data", got_data[k], hi * 256 + lo);
    end
    chk(done_cnt == 1, "R9 done pulse count", done_cnt, 1);
    chk(line_err_o == (lc % 2), "R7 odd line flag", int'(line_err_o), lc % 2);
    chk(ovf_err_o == (L > LP), "R8 overflow flag", int'(ovf_err_o), int'(L > LP));
    saved = wr_cnt;
    send_line(L, 0, 4);
    repeat (2) @(negedge clk);
    chk(wr_cnt == saved, "R9 ignored after done", wr_cnt, saved);
    chk(int'(line_cnt_o) == FL, "R9 count frozen after done", int'(line_cnt_o), FL);
    chk(done_cnt == 1, "R9 no second done", done_cnt, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; vsync_i = 1'b0; hvalid_i = 1'b0; pix_i = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!wr_en_o && !done_o && !line_err_o && !ovf_err_o && line_cnt_o == 0,
        "R1 reset state", int'(wr_en_o) + int'(done_o) + int'(line_cnt_o), 0);
    // Line activity before any frame start
    send_line(0, 0, 5);
    send_line(0, 1, 8);
    chk(wr_cnt == 0, "R2 no write before frame", wr_cnt, 0);
    chk(line_cnt_o == 0 && !ovf_err_o && !line_err_o, "R2 no count before frame",
        int'(line_cnt_o), 0);
    // Line length sweep: odd, even, at limit, over limit
    for (int L = 1; L <= 8; L++) run_frame(L);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule